// File: doc/BRIEF.md
# Nested Four-Level Interrupt Controller

This block picks which interrupt request a small 8-bit processor core should service next, and it tracks how deeply service routines are nested. There are fifteen request sources. Sources 0 and 1 come from two active-low external pins, and each pin can be set to respond to a low level or to a falling edge. Sources 2 to 14 are level requests from on-chip peripherals. Every source has its own enable bit, and one master enable gates all of them. Each source is given one of four priority levels, built from a low bit and a high bit that are held in separate configuration registers.

The core pulses `instr_edge` at each instruction boundary. On that cycle the controller looks at every eligible request and picks the one with the highest level. When two or more requests share that level, the lowest source index wins. The winner is accepted only if its level is strictly above the highest level already in service. The controller then pulses `irq_ack` for one cycle and drives the winner's index on `irq_vec`. The core pulses `iret` when a service routine ends, and this retires the highest active level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_ack` is 0 and `irq_vec` is 0. All enables, priority bits and trigger modes are 0, and no level is in service. A boundary with every request raised therefore produces no acknowledge.
- R2: A request is accepted only if its own enable bit is 1. Register 0 bits 6..0 enable sources 0..6. Register 1 bits 7..0 enable sources 7..14.
- R3: Register 0 bit 7 is the master enable. While it is 0, no request is accepted, whatever the per-source enables hold.
- R4: A source's level is {high bit, low bit}. Registers 2 (low) and 3 (high) hold bit i for source i, for sources 0..7. Registers 4 (low) and 5 (high) hold bit i-8 for source i, for sources 8..14. Writes use `cfg_we`, `cfg_addr` and `cfg_wdata`, and they take effect from the next cycle.
- R5: Requests are arbitrated only in a cycle where `instr_edge` is 1. On acceptance, `irq_ack` is 1 for exactly the following cycle and `irq_vec` carries the 4-bit source index. With no boundary, nothing is acknowledged.
- R6: Among eligible requests of different levels, the highest level wins, whatever the source indices are.
- R7: Among eligible requests of the same top level, the lowest source index wins.
- R8: While a level is in service, a request is accepted only if its level is strictly above the current level. Equal or lower requests stay pending.
- R9: While level 3 is in service, no request is accepted.
- R10: A pulse on `iret` retires the highest level in service. The next lower active level, if any, then becomes the current level.
- R11: Sources 0 and 1 follow `ext_pin_n[0]` and `ext_pin_n[1]`. Register 2+4=6 bit e selects the mode of pin e: 0 means level and 1 means edge. In level mode the request is active while the pin is low.
- R12: In edge mode, a falling edge on the pin latches a request. The latch stays set after the pin returns high and is cleared when that source is accepted. A pin held low yields only one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External request pins, active low (sources 0 and 1) |
| periph_req | input | 13 | Peripheral level requests; bit k is source k+2 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0..6) |
| cfg_wdata | input | 8 | Configuration write data |
| instr_edge | input | 1 | Instruction-boundary strobe |
| iret | input | 1 | Return from a service routine |
| irq_ack | output | 1 | One-cycle acknowledge of an accepted request |
| irq_vec | output | 4 | Index of the accepted source |

## Verification
A corrupted in-service record shows up at the next boundary, in one of two ways. A request that should preempt is withheld, or one that should wait is acknowledged a cycle later. A bad `iret` pop likewise shows up only at the first boundary after the return. A lost or stuck edge latch on an external pin shows as a missing acknowledge, or a repeated one, at the following boundary. The bench therefore compares `irq_ack` and `irq_vec` against a behavioural model on every cycle. It also checks hard-coded outcomes for each preemption, tie and trigger case.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
   localparam int unsigned NIRQ_LEVELS = 4;
   typedef logic [1:0] nirq_lvl_t;

   // configuration register map
   localparam int unsigned REG_EN_LO   = 0;
   localparam int unsigned REG_EN_HI   = 1;
   localparam int unsigned REG_PL_LO   = 2;
   localparam int unsigned REG_PH_LO   = 3;
   localparam int unsigned REG_PL_HI   = 4;
   localparam int unsigned REG_PH_HI   = 5;
   localparam int unsigned REG_TRIG    = 6;
endpackage

// File: rtl/nirq_cfg.sv
module nirq_cfg #(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_EXT = 2,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic               glob_en,
   output logic [NUM_SRC-1:0] en_vec,
   output logic [NUM_SRC-1:0] plo_vec,
   output logic [NUM_SRC-1:0] phi_vec,
   output logic [NUM_EXT-1:0] edge_mode
);
   import nirq_pkg::*;

   localparam int unsigned EN_SPLIT = DATA_W - 1;
   localparam int unsigned PR_SPLIT = DATA_W;

   logic hit_en_lo, hit_en_hi, hit_pl_lo, hit_ph_lo, hit_pl_hi, hit_ph_hi, hit_trig;

   always_comb begin
      hit_en_lo = we && (addr == ADDR_W'(REG_EN_LO));
      hit_en_hi = we && (addr == ADDR_W'(REG_EN_HI));
      hit_pl_lo = we && (addr == ADDR_W'(REG_PL_LO));
      hit_ph_lo = we && (addr == ADDR_W'(REG_PH_LO));
      hit_pl_hi = we && (addr == ADDR_W'(REG_PL_HI));
      hit_ph_hi = we && (addr == ADDR_W'(REG_PH_HI));
      hit_trig  = we && (addr == ADDR_W'(REG_TRIG));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         glob_en <= 1'b0;
      else if (hit_en_lo) glob_en <= wdata[DATA_W-1];
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic en_hit, pl_hit, ph_hit, en_bit, pl_bit, ph_bit;
      if (i < EN_SPLIT) begin : g_en_lo
         assign en_hit = hit_en_lo;
         assign en_bit = wdata[i];
      end else begin : g_en_hi
         assign en_hit = hit_en_hi;
         assign en_bit = wdata[i-EN_SPLIT];
      end
      if (i < PR_SPLIT) begin : g_pr_lo
         assign pl_hit = hit_pl_lo;
         assign ph_hit = hit_ph_lo;
         assign pl_bit = wdata[i];
         assign ph_bit = wdata[i];
      end else begin : g_pr_hi
         assign pl_hit = hit_pl_hi;
         assign ph_hit = hit_ph_hi;
         assign pl_bit = wdata[i-PR_SPLIT];
         assign ph_bit = wdata[i-PR_SPLIT];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_vec[i]  <= 1'b0;
            plo_vec[i] <= 1'b0;
            phi_vec[i] <= 1'b0;
         end else begin
            if (en_hit) en_vec[i]  <= en_bit;
            if (pl_hit) plo_vec[i] <= pl_bit;
            if (ph_hit) phi_vec[i] <= ph_bit;
         end
      end
   end

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        edge_mode[e] <= 1'b0;
         else if (hit_trig) edge_mode[e] <= wdata[e];
      end
   end
endmodule

// File: rtl/nirq_ext.sv
module nirq_ext #(
   parameter int unsigned NUM_EXT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] pin_n,
   input  logic [NUM_EXT-1:0] edge_mode,
   input  logic [NUM_EXT-1:0] taken,
   output logic [NUM_EXT-1:0] req
);
   for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
      logic prev_q, latch_q, fall;
      assign fall = prev_q && !pin_n[e];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
         end else begin
            prev_q <= pin_n[e];
            if (!edge_mode[e]) latch_q <= 1'b0;
            else if (fall)     latch_q <= 1'b1;
            else if (taken[e]) latch_q <= 1'b0;
         end
      end
      assign req[e] = edge_mode[e] ? latch_q : !pin_n[e];
   end
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb #(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned VEC_W   = 4
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en_vec,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] plo_vec,
   input  logic [NUM_SRC-1:0] phi_vec,
   input  logic               cur_any,
   input  nirq_pkg::nirq_lvl_t cur_lvl,
   output logic               found,
   output logic [VEC_W-1:0]   win_idx,
   output nirq_pkg::nirq_lvl_t win_lvl
);
   import nirq_pkg::*;

   nirq_lvl_t    lv [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign lv[i]   = {phi_vec[i], plo_vec[i]};
      assign elig[i] = pend[i] && en_vec[i] && glob_en && (!cur_any || (lv[i] > cur_lvl));
   end

   // descending scan with >= leaves the lowest index among the top level
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!found || (lv[i] >= win_lvl))) begin
            found   = 1'b1;
            win_idx = VEC_W'(i);
            win_lvl = lv[i];
         end
      end
   end
endmodule

// File: rtl/nirq_nest.sv
module nirq_nest (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  nirq_pkg::nirq_lvl_t push_lvl,
   input  logic                pop,
   output logic [nirq_pkg::NIRQ_LEVELS-1:0] isr_q,
   output logic                any,
   output nirq_pkg::nirq_lvl_t top_lvl
);
   import nirq_pkg::*;

   logic [NIRQ_LEVELS-1:0] top_oh, push_oh, isr_d;

   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < int'(NIRQ_LEVELS); l++)
         if (isr_q[l]) top_lvl = nirq_lvl_t'(l);
   end

   assign any     = |isr_q;
   assign top_oh  = NIRQ_LEVELS'(1) << top_lvl;
   assign push_oh = NIRQ_LEVELS'(1) << push_lvl;

   always_comb begin
      isr_d = isr_q;
      if (pop && any) isr_d = isr_d & ~top_oh;
      if (push)       isr_d = isr_d | push_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned NUM_EXT = 2,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned VEC_W  = $clog2(NUM_SRC),
   localparam int unsigned NUM_PER = NUM_SRC - NUM_EXT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_pin_n,
   input  logic [NUM_PER-1:0] periph_req,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_wdata,
   input  logic               instr_edge,
   input  logic               iret,
   output logic               irq_ack,
   output logic [VEC_W-1:0]   irq_vec
);
   import nirq_pkg::*;

   if ((NUM_SRC <= DATA_W) || (NUM_SRC > 2*DATA_W - 1)) begin : g_bad_src
      $error("NUM_SRC must lie in DATA_W+1 .. 2*DATA_W-1");
   end
   if ((NUM_EXT < 1) || (NUM_EXT > DATA_W) || (NUM_EXT >= NUM_SRC)) begin : g_bad_ext
      $error("NUM_EXT out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   logic               glob_en;
   logic [NUM_SRC-1:0] en_vec, plo_vec, phi_vec, pend;
   logic [NUM_EXT-1:0] edge_mode, ext_req, ext_taken;
   logic               win_found, cur_any, accept;
   logic [VEC_W-1:0]   win_idx;
   nirq_lvl_t          win_lvl, cur_lvl;
   logic [NIRQ_LEVELS-1:0] isr_q;

   nirq_cfg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .glob_en(glob_en), .en_vec(en_vec), .plo_vec(plo_vec), .phi_vec(phi_vec),
      .edge_mode(edge_mode));

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_take
      assign ext_taken[e] = accept && (win_idx == VEC_W'(e));
   end

   nirq_ext #(.NUM_EXT(NUM_EXT)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n), .edge_mode(edge_mode),
      .taken(ext_taken), .req(ext_req));

   assign pend = {periph_req, ext_req};

   nirq_arb #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
      .pend(pend), .en_vec(en_vec), .glob_en(glob_en), .plo_vec(plo_vec),
      .phi_vec(phi_vec), .cur_any(cur_any), .cur_lvl(cur_lvl),
      .found(win_found), .win_idx(win_idx), .win_lvl(win_lvl));

   assign accept = instr_edge && win_found;

   nirq_nest u_nest (
      .clk(clk), .rst_n(rst_n), .push(accept), .push_lvl(win_lvl), .pop(iret),
      .isr_q(isr_q), .any(cur_any), .top_lvl(cur_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_ack <= 1'b0;
         irq_vec <= '0;
      end else begin
         irq_ack <= accept;
         if (accept) irq_vec <= win_idx;
      end
   end
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk #(
   parameter int unsigned NUM_SRC = 15,
   localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                instr_edge,
   input logic                irq_ack,
   input logic [VEC_W-1:0]    irq_vec,
   input logic                glob_en,
   input logic [nirq_pkg::NIRQ_LEVELS-1:0] isr,
   input logic                win_found,
   input nirq_pkg::nirq_lvl_t win_lvl,
   input logic                cur_any,
   input nirq_pkg::nirq_lvl_t cur_lvl
);
   a_r5_ack_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> $past(instr_edge));

   a_r5_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (int'(irq_vec) < int'(NUM_SRC)));

   a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> $past(glob_en));

   a_r8_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_edge && win_found && cur_any) |-> (win_lvl > cur_lvl));

   a_r9_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      isr[3] |=> !irq_ack);

   a_r10_ack_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (isr != '0));
endmodule

bind nest_irq_ctrl nirq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_edge(instr_edge), .irq_ack(irq_ack),
   .irq_vec(irq_vec), .glob_en(glob_en), .isr(isr_q), .win_found(win_found),
   .win_lvl(win_lvl), .cur_any(cur_any), .cur_lvl(cur_lvl));

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_pin_n = 2'b11;
   logic [12:0] periph_req = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        instr_edge = 1'b0;
   logic        iret = 1'b0;
   logic        irq_ack;
   logic [3:0]  irq_vec;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nest_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .periph_req(periph_req),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .instr_edge(instr_edge), .iret(iret), .irq_ack(irq_ack), .irq_vec(irq_vec));

   // ---------------- behavioural reference model ----------------
   bit m_gen;
   bit m_en [NSRC];
   bit m_lo [NSRC];
   bit m_hi [NSRC];
   bit m_mode [2];
   bit m_flag [2];
   bit m_prev [2];
   int m_stack [$];
   bit exp_ack;
   int exp_vec;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gen = 0;
         for (int i = 0; i < NSRC; i++) begin m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
         for (int e = 0; e < 2; e++) begin m_mode[e] = 0; m_flag[e] = 0; m_prev[e] = 1; end
         m_stack.delete();
         exp_ack = 0;
         exp_vec = 0;
      end else begin
         int win, wl, cur;
         win = -1; wl = -1;
         cur = (m_stack.size() > 0) ? m_stack[m_stack.size()-1] : -1;
         if (instr_edge && m_gen) begin
            for (int i = 0; i < NSRC; i++) begin
               bit p;
               int l;
               if (i < 2) p = m_mode[i] ? m_flag[i] : !ext_pin_n[i];
               else       p = periph_req[i-2];
               l = 2*int'(m_hi[i]) + int'(m_lo[i]);
               if (p && m_en[i] && l > cur && l > wl) begin win = i; wl = l; end
            end
         end
         if (iret && m_stack.size() > 0) void'(m_stack.pop_back());
         if (win >= 0) m_stack.push_back(wl);
         exp_ack = (win >= 0);
         if (win >= 0) exp_vec = win;
         for (int e = 0; e < 2; e++) begin
            bit fall;
            fall = m_prev[e] && !ext_pin_n[e];
            if (!m_mode[e])    m_flag[e] = 0;
            else if (fall)     m_flag[e] = 1;
            else if (win == e) m_flag[e] = 0;
            m_prev[e] = ext_pin_n[e];
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: begin m_gen = cfg_wdata[7]; for (int k = 0; k < 7; k++) m_en[k] = cfg_wdata[k]; end
               3'd1: for (int k = 0; k < 8; k++) m_en[7+k] = cfg_wdata[k];
               3'd2: for (int k = 0; k < 8; k++) m_lo[k] = cfg_wdata[k];
               3'd3: for (int k = 0; k < 8; k++) m_hi[k] = cfg_wdata[k];
               3'd4: for (int k = 0; k < 7; k++) m_lo[8+k] = cfg_wdata[k];
               3'd5: for (int k = 0; k < 7; k++) m_hi[8+k] = cfg_wdata[k];
               3'd6: begin m_mode[0] = cfg_wdata[0]; m_mode[1] = cfg_wdata[1]; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(irq_ack == exp_ack, cur_tag, int'(irq_ack), int'(exp_ack));
         if (exp_ack) chk(int'(irq_vec) == exp_vec, cur_tag, int'(irq_vec), exp_vec);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wr(input int a, input int d);
      step(); cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
      step(); cfg_we = 0;
   endtask

   task automatic boundary();
      step(); instr_edge = 1;
      step(); instr_edge = 0;
   endtask

   task automatic ret();
      step(); iret = 1;
      step(); iret = 0;
   endtask

   task automatic expect_ack(input int v, input string tag);
      chk(irq_ack == 1'b1, tag, int'(irq_ack), 1);
      chk(int'(irq_vec) == v, tag, int'(irq_vec), v);
   endtask

   task automatic expect_none(input string tag);
      chk(irq_ack == 1'b0, tag, int'(irq_ack), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      // R1 reset state
      cur_tag = "R1";
      chk(irq_ack == 1'b0, "R1", int'(irq_ack), 0);
      chk(irq_vec == 4'd0, "R1", int'(irq_vec), 0);
      ext_pin_n = 2'b00; periph_req = '1;
      boundary(); expect_none("R1");
      ext_pin_n = 2'b11; periph_req = '0;

      // R3 master enable, R5 timing
      cur_tag = "R3";
      wr(1, 8'h00); wr(0, 8'h20);
      periph_req[3] = 1;
      boundary(); expect_none("R3");
      cur_tag = "R5";
      wr(0, 8'hA0);
      repeat (3) step();
      expect_none("R5");
      boundary(); expect_ack(5, "R5");
      step(); expect_none("R5");
      periph_req = '0; ret();

      // R2 per-source enable
      cur_tag = "R2";
      wr(0, 8'h80);
      periph_req[7] = 1;
      boundary(); expect_none("R2");
      wr(1, 8'h04);
      boundary(); expect_ack(9, "R2");
      periph_req = '0; ret();

      // R4/R6 priorities: src3=1, src10=2, src12=2, src13=3
      cur_tag = "R6";
      wr(2, 8'h08); wr(3, 8'h00); wr(4, 8'h20); wr(5, 8'h34);
      wr(0, 8'h88); wr(1, 8'h68);
      periph_req[1] = 1; periph_req[10] = 1;
      boundary(); expect_ack(12, "R6");
      periph_req[10] = 0;
      cur_tag = "R8";
      boundary(); expect_none("R8");
      periph_req[8] = 1;
      boundary(); expect_none("R8");
      periph_req[11] = 1;
      boundary(); expect_ack(13, "R8");
      periph_req[11] = 0;
      cur_tag = "R9";
      boundary(); expect_none("R9");
      cur_tag = "R10";
      ret();
      boundary(); expect_none("R10");
      ret();
      cur_tag = "R4";
      boundary(); expect_ack(10, "R4");
      periph_req[8] = 0; ret();
      boundary(); expect_ack(3, "R4");
      periph_req = '0; ret();

      // R7 same level, lowest index wins
      cur_tag = "R7";
      wr(2, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
      wr(0, 8'hD0); wr(1, 8'h10);
      periph_req[2] = 1; periph_req[4] = 1; periph_req[9] = 1;
      boundary(); expect_ack(4, "R7");
      periph_req[2] = 0; ret();
      boundary(); expect_ack(6, "R7");
      periph_req = '0; ret();

      // R11 level mode on pin 0
      cur_tag = "R11";
      wr(1, 8'h00); wr(0, 8'h81); wr(6, 8'h00);
      step(); ext_pin_n[0] = 0;
      boundary(); expect_ack(0, "R11");
      ext_pin_n[0] = 1; ret();
      boundary(); expect_none("R11");

      // R12 edge mode on pin 1
      cur_tag = "R12";
      wr(0, 8'h82); wr(6, 8'h02);
      step(); ext_pin_n[1] = 0;
      step(); ext_pin_n[1] = 1;
      repeat (2) step();
      boundary(); expect_ack(1, "R12");
      ret();
      boundary(); expect_none("R12");
      step(); ext_pin_n[1] = 0;
      boundary(); expect_ack(1, "R12");
      ret();
      boundary(); expect_none("R12");
      ext_pin_n[1] = 1;
      repeat (3) step();
      finish_run();
   end
endmodule